// File: doc/BRIEF.md
# Converter Serial Readout and Configuration Port

This block is the digital side of a delta-sigma converter's four-wire serial port, with the port supplying its own serial clock. After reset it models a conversion with a timer whose length follows the stored speed setting. When the timer expires it captures the result word from its input port and drops SDO low as an end-of-conversion indication. It then waits for chip select to be low for a set number of clocks. After that it produces 32 serial clock pulses on its own, shifting out a frame made of the end-of-conversion bit followed by the result.

During the same frame it takes in a configuration word from SDI, most significant bit first, one bit on each rising SCK edge. The word selects the input channel and the speed setting. Chip select may rise at any time during the frame to cut it short. In that case a new conversion starts at once. How far the frame got decides which parts of the new configuration survive. The speed field is committed once the 13th bit has been taken in, and the channel field only after the following falling SCK edge.

Top module: `adc_serial_port`

## Requirements
- R1: While reset is high, and after it, SCK and SDO are 1, BUSY is 1, channel and speed hold their default values (0), and a conversion begins.
- R2: A conversion lasts CONV_BASE*(speed+1) clock cycles, using the speed value stored when it starts. SDO is 1 for exactly that many cycles, and SCK stays 1 throughout.
- R3: Once a conversion has finished, SCK stays 1 for as long as CS is held high.
- R4: Once a conversion has finished, SCK first falls right after CS has been sampled low on START_DLY consecutive clock edges. A bench that lowers CS sees SCK high for exactly START_DLY cycles.
- R5: During a frame, SCK toggles every HALF_DIV clock cycles, starting with a falling edge. A complete frame has exactly 32 rising edges.
- R6: The frame is {1'b0, result[30:0]}, sent MSB first. The bit that a receiver samples on rising edge k is frame bit 32-k, so rising edge 1 reads the end-of-conversion bit as 0. SDO changes during a frame only on falling SCK edges.
- R7: HALF_DIV cycles after the 32nd rising edge, SDO goes to 1, SCK stays 1, and a new conversion starts.
- R8: If CS is high on any clock edge during a frame, the next clock cycle shows SCK = 1 and SDO = 1, and a new conversion runs.
- R9: SDI is sampled on the rising SCK edges 1 to 13, forming a 13-bit word W (the first bit taken is W[12]). W[12:9] is the channel, W[8:5] is the speed, and W[4:0] and SDI after edge 13 have no effect.
- R10: The speed output takes W[8:5] on the 13th rising edge. A frame aborted before that edge leaves the speed unchanged.
- R11: The channel output takes W[12:9] on the 14th falling edge. A frame aborted before that edge leaves the channel unchanged, even if the speed changed.
- R12: BUSY is 0 exactly while a finished result waits for its frame. During that time SDO is 0 and SCK is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select, active low, synchronous to clk_i |
| sdi_i | input | 1 | Serial configuration input |
| result_i | input | FRAME_BITS-1 | Conversion result, captured when the conversion ends |
| sdo_o | output | 1 | Serial data out; end-of-conversion flag outside a frame |
| sck_o | output | 1 | Generated serial clock, idle high |
| busy_o | output | 1 | High while converting or shifting |
| chan_o | output | CH_W | Committed channel selection |
| speed_o | output | SPD_W | Committed speed setting |

## Verification
The properties assume that CS and SDI are synchronous to the system clock. SDI may change only after a falling SCK edge. CS may change only away from SCK edges, and HALF_DIV is at least 2, so a CS rise is seen before the next SCK edge. result_i must be held steady until the next conversion ends. The bench drives every input on the falling clock edge, changes SDI only after it has seen SCK fall, and raises CS for an abort only after it has counted a given SCK edge. It loads a new result as each conversion starts.

// File: rtl/asp_pkg.sv
package asp_pkg;
  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_READY = 2'd1,
    ST_SHIFT = 2'd2
  } port_state_e;
endpackage

// File: rtl/asp_sck_gen.sv
// Serial clock divider: idle high, first toggle is a falling edge.
module asp_sck_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic run_i,
  input  logic hold_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o,
  output logic end_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          sck_q;
  logic          tick;

  assign tick   = run_i && (cnt_q == CW'(HALF_DIV - 1));
  assign rise_o = tick && !sck_q;
  assign fall_o = tick && sck_q && !hold_i;
  assign end_o  = tick && sck_q && hold_i;
  assign sck_o  = sck_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i) begin
      sck_q <= 1'b1;
      cnt_q <= CW'(HALF_DIV - 1);
    end else if (tick) begin
      cnt_q <= '0;
      if (!hold_i || !sck_q) sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/asp_conv_timer.sv
// Conversion time model: CONV_BASE*(speed+1) cycles per conversion.
module asp_conv_timer #(
  parameter int SPD_W     = 4,
  parameter int CONV_BASE = 64,
  parameter int DEF_SPD   = 0
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic [SPD_W-1:0] speed_i,
  output logic             done_o
);
  localparam int MAXLEN = CONV_BASE * (2 ** SPD_W);
  localparam int CW     = $clog2(MAXLEN);

  function automatic logic [CW-1:0] len_m1(input logic [SPD_W-1:0] s);
    return CW'(CONV_BASE * (int'(s) + 1) - 1);
  endfunction

  logic [CW-1:0] cnt_q;
  logic          act_q;

  assign done_o = act_q && (cnt_q == '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= len_m1(SPD_W'(DEF_SPD));
      act_q <= 1'b1;
    end else if (start_i) begin
      cnt_q <= len_m1(speed_i);
      act_q <= 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/asp_cfg_rx.sv
// Configuration receiver: speed commits at rise CFG_BITS, channel at the next fall.
module asp_cfg_rx #(
  parameter int CFG_BITS = 13,
  parameter int CH_W     = 4,
  parameter int SPD_W    = 4,
  parameter int IDX_W    = 6,
  parameter int DEF_CH   = 0,
  parameter int DEF_SPD  = 0
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             sdi_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [CH_W-1:0]  chan_o,
  output logic [SPD_W-1:0] speed_o
);
  localparam int FW = CH_W + SPD_W;

  logic [FW-1:0]   fld_q;
  logic [CH_W-1:0] pend_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      fld_q   <= '0;
      pend_q  <= CH_W'(DEF_CH);
      chan_o  <= CH_W'(DEF_CH);
      speed_o <= SPD_W'(DEF_SPD);
    end else begin
      if (rise_i && (idx_i < IDX_W'(FW)))
        fld_q <= {fld_q[FW-2:0], sdi_i};
      if (rise_i && (idx_i == IDX_W'(CFG_BITS - 1))) begin
        speed_o <= fld_q[SPD_W-1:0];
        pend_q  <= fld_q[FW-1:SPD_W];
      end
      if (fall_i && (idx_i == IDX_W'(CFG_BITS)))
        chan_o <= pend_q;
    end
  end
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int FRAME_BITS = 32,
  parameter int CFG_BITS   = 13,
  parameter int CH_W       = 4,
  parameter int SPD_W      = 4,
  parameter int HALF_DIV   = 2,
  parameter int START_DLY  = 8,
  parameter int CONV_BASE  = 64,
  parameter int DEF_CH     = 0,
  parameter int DEF_SPD    = 0
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  cs_i,
  input  logic                  sdi_i,
  input  logic [FRAME_BITS-2:0] result_i,
  output logic                  sdo_o,
  output logic                  sck_o,
  output logic                  busy_o,
  output logic [CH_W-1:0]       chan_o,
  output logic [SPD_W-1:0]      speed_o
);
  import asp_pkg::*;

  localparam int IDX_W = $clog2(FRAME_BITS + 1);
  localparam int DLY_W = (START_DLY > 1) ? $clog2(START_DLY) : 1;

  port_state_e           state_q;
  logic [DLY_W-1:0]      dly_q;
  logic [IDX_W-1:0]      rise_cnt_q;
  logic [FRAME_BITS-1:0] frame_q;
  logic                  busy_q;

  logic run_s, hold_s, rise_s, fall_s, end_s, done_s, abort_s, start_s;

  assign run_s   = (state_q == ST_SHIFT) && !cs_i;
  assign abort_s = (state_q == ST_SHIFT) && cs_i;
  assign hold_s  = (rise_cnt_q == IDX_W'(FRAME_BITS));
  assign start_s = abort_s || end_s;

  asp_sck_gen #(.HALF_DIV(HALF_DIV)) u_sck (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .run_i (run_s),
    .hold_i(hold_s),
    .sck_o (sck_o),
    .rise_o(rise_s),
    .fall_o(fall_s),
    .end_o (end_s)
  );

  asp_conv_timer #(
    .SPD_W(SPD_W), .CONV_BASE(CONV_BASE), .DEF_SPD(DEF_SPD)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .start_i(start_s),
    .speed_i(speed_o),
    .done_o (done_s)
  );

  asp_cfg_rx #(
    .CFG_BITS(CFG_BITS), .CH_W(CH_W), .SPD_W(SPD_W),
    .IDX_W(IDX_W), .DEF_CH(DEF_CH), .DEF_SPD(DEF_SPD)
  ) u_cfg (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .sdi_i  (sdi_i),
    .rise_i (rise_s),
    .fall_i (fall_s),
    .idx_i  (rise_cnt_q),
    .chan_o (chan_o),
    .speed_o(speed_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q    <= ST_CONV;
      dly_q      <= '0;
      rise_cnt_q <= '0;
      frame_q    <= '1;
      busy_q     <= 1'b1;
    end else begin
      case (state_q)
        ST_CONV: begin
          if (done_s) begin
            state_q <= ST_READY;
            frame_q <= {1'b0, result_i};
            busy_q  <= 1'b0;
            dly_q   <= '0;
          end
        end
        ST_READY: begin
          if (cs_i) begin
            dly_q <= '0;
          end else if (dly_q == DLY_W'(START_DLY - 1)) begin
            state_q    <= ST_SHIFT;
            busy_q     <= 1'b1;
            rise_cnt_q <= '0;
            dly_q      <= '0;
          end else begin
            dly_q <= dly_q + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (start_s) begin
            state_q <= ST_CONV;
            frame_q <= '1;
          end else begin
            if (rise_s) rise_cnt_q <= rise_cnt_q + 1'b1;
            if (fall_s && (rise_cnt_q != '0))
              frame_q <= {frame_q[FRAME_BITS-2:0], 1'b1};
          end
        end
        default: state_q <= ST_CONV;
      endcase
    end
  end

  assign sdo_o  = frame_q[FRAME_BITS-1];
  assign busy_o = busy_q;
endmodule

// File: rtl/asp_chk.sv
module asp_chk #(
  parameter int FRAME_BITS = 32,
  parameter int CH_W       = 4,
  parameter int SPD_W      = 4,
  parameter int IDX_W      = 6
) (
  input logic                  clk_i,
  input logic                  rst_i,
  input logic                  cs_i,
  input logic                  sck_o,
  input logic                  sdo_o,
  input logic                  busy_o,
  input logic [CH_W-1:0]       chan_o,
  input logic [SPD_W-1:0]      speed_o,
  input asp_pkg::port_state_e  st_i,
  input logic [IDX_W-1:0]      rise_cnt_i
);
  import asp_pkg::*;

  assert_wait_idle_R12: assert property (@(posedge clk_i) disable iff (rst_i)
    !busy_o |-> (sck_o && !sdo_o));

  assert_ready_sck_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_i == ST_READY) |-> sck_o);

  assert_sdo_on_fall_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    ((st_i == ST_SHIFT) && ($past(st_i) == ST_SHIFT) && (sdo_o != $past(sdo_o)))
      |-> $fell(sck_o));

  assert_abort_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    ((st_i == ST_SHIFT) && cs_i) |=> (sck_o && sdo_o && (st_i == ST_CONV)));

  assert_cfg_hold_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_i != ST_SHIFT) |=> ($stable(chan_o) && $stable(speed_o)));

  assert_rise_bound_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    rise_cnt_i <= IDX_W'(FRAME_BITS));

  assert_tail_high_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    ((st_i == ST_SHIFT) && (rise_cnt_i == IDX_W'(FRAME_BITS))) |-> sck_o);
endmodule

bind adc_serial_port asp_chk #(
  .FRAME_BITS(FRAME_BITS), .CH_W(CH_W), .SPD_W(SPD_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .cs_i      (cs_i),
  .sck_o     (sck_o),
  .sdo_o     (sdo_o),
  .busy_o    (busy_o),
  .chan_o    (chan_o),
  .speed_o   (speed_o),
  .st_i      (state_q),
  .rise_cnt_i(rise_cnt_q)
);

// File: tb/tb_adc_serial_port.sv
module tb_adc_serial_port;
  localparam int FRAME_BITS = 32;
  localparam int CFG_BITS   = 13;
  localparam int CH_W       = 4;
  localparam int SPD_W      = 4;
  localparam int HALF_DIV   = 2;
  localparam int START_DLY  = 8;
  localparam int CONV_BASE  = 64;

  logic clk = 1'b0;
  logic rst, cs, sdi;
  logic [FRAME_BITS-2:0] result;
  logic sdo, sck, busy;
  logic [CH_W-1:0]  chan;
  logic [SPD_W-1:0] speed;

  int checks = 0;
  int fails  = 0;
  int exp_ch  = 0;
  int exp_spd = 0;
  logic [FRAME_BITS-1:0] exp_frame;

  always #2 clk = ~clk;

  adc_serial_port #(
    .FRAME_BITS(FRAME_BITS), .CFG_BITS(CFG_BITS), .CH_W(CH_W), .SPD_W(SPD_W),
    .HALF_DIV(HALF_DIV), .START_DLY(START_DLY), .CONV_BASE(CONV_BASE),
    .DEF_CH(0), .DEF_SPD(0)
  ) dut (
    .clk_i(clk), .rst_i(rst), .cs_i(cs), .sdi_i(sdi), .result_i(result),
    .sdo_o(sdo), .sck_o(sck), .busy_o(busy), .chan_o(chan), .speed_o(speed)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int conv_len(input int spd);
    return CONV_BASE * (spd + 1);
  endfunction

  // Measure the conversion that starts at the current falling clock edge (R2).
  task automatic measure_conv();
    int n = 0;
    int sck_bad = 0;
    while (sdo && n < 5000) begin
      if (!sck) sck_bad++;
      n++;
      @(negedge clk);
    end
    check(n == conv_len(exp_spd), "R2 conversion length", n, conv_len(exp_spd));
    check(sck_bad == 0, "R2 sck high while converting", sck_bad, 0);
    check(!busy && !sdo && sck, "R12 waiting state", {busy, sdo, sck}, 3'b001);
  endtask

  // One readout frame; ab = SCK edge count after which CS rises, -1 for none.
  task automatic do_frame(input logic [CFG_BITS-1:0] cfg, input int ab);
    int edges = 1, rises = 0, falls = 1, gap = 0;
    int bit_err = 0, per_err = 0, busy_err = 0, wt = 0;
    bit prev = 1'b0;
    bit done = 1'b0;
    int new_ch  = int'(cfg[12:9]);
    int new_spd = int'(cfg[8:5]);
    int idle_bad = 0;
    repeat (6) begin
      @(negedge clk);
      if (!sck || busy) idle_bad++;
    end
    check(idle_bad == 0, "R3 no sck while cs high", idle_bad, 0);
    cs = 1'b0;
    @(negedge clk);
    while (sck && wt < 100) begin
      wt++;
      @(negedge clk);
    end
    check(wt == START_DLY, "R4 start delay", wt, START_DLY);
    sdi = cfg[CFG_BITS-1];
    if (ab == 1) begin
      cs = 1'b1;
      done = 1'b1;
    end
    while (!done) begin
      @(negedge clk);
      gap++;
      if (!busy) busy_err++;
      if (sck != prev) begin
        edges++;
        if (gap != HALF_DIV) per_err++;
        gap = 0;
        prev = sck;
        if (sck) begin
          rises++;
          if (sdo != exp_frame[FRAME_BITS-rises]) bit_err++;
        end else begin
          falls++;
          sdi = (falls <= CFG_BITS) ? cfg[CFG_BITS-falls] : 1'($urandom);
        end
        if (edges == ab) begin
          cs = 1'b1;
          done = 1'b1;
        end else if (rises == FRAME_BITS) begin
          done = 1'b1;
        end
      end
    end
    check(bit_err == 0, "R6 received bits", bit_err, 0);
    check(per_err == 0, "R5 sck half period", per_err, 0);
    check(busy_err == 0, "R12 busy during frame", busy_err, 0);
    if (ab < 0) begin
      check(rises == FRAME_BITS, "R5 rising edge count", rises, FRAME_BITS);
      repeat (HALF_DIV) @(negedge clk);
      check(sck && sdo, "R7 frame end idle", {sck, sdo}, 2'b11);
      cs = 1'b1;
    end else begin
      @(negedge clk);
      check(sck && sdo, "R8 abort idle", {sck, sdo}, 2'b11);
    end
    if (ab < 0 || ab >= 2 * CFG_BITS)     exp_spd = new_spd;
    if (ab < 0 || ab >= 2 * CFG_BITS + 1) exp_ch  = new_ch;
    check(int'(speed) == exp_spd, "R10 R9 speed commit", speed, exp_spd);
    check(int'(chan) == exp_ch, "R11 R9 channel commit", chan, exp_ch);
    result = (FRAME_BITS-1)'($urandom);
    exp_frame = {1'b0, result};
    measure_conv();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R2 actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'd20240611);
    rst = 1'b1;
    cs = 1'b1;
    sdi = 1'b0;
    result = (FRAME_BITS-1)'($urandom);
    exp_frame = {1'b0, result};
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(sck && sdo && busy, "R1 reset outputs", {sck, sdo, busy}, 3'b111);
    check(chan == 0 && speed == 0, "R1 reset config", {chan, speed}, 0);
    rst = 1'b0;
    while (sdo) @(negedge clk);
    check(!busy && sck, "R12 first result ready", {busy, sck}, 2'b01);
    // Directed cases: full frame, then aborts around the commit edges.
    do_frame({4'd5,  4'd3,  5'b10101}, -1);
    do_frame({4'd9,  4'd7,  5'b00000}, 1);
    do_frame({4'd12, 4'd9,  5'b11111}, 25);
    do_frame({4'd2,  4'd6,  5'b01010}, 26);
    do_frame({4'd14, 4'd1,  5'b00110}, 27);
    do_frame({4'd7,  4'd15, 5'b11001}, 63);
    for (int i = 0; i < 30; i++) begin
      logic [CFG_BITS-1:0] c;
      int a;
      c = CFG_BITS'($urandom);
      a = ($urandom % 3 == 0) ? -1 : int'(1 + $urandom % 63);
      do_frame(c, a);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule